// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address of each data beat of one synchronous DRAM burst, one address per clock. It serves a device model, a controller or a memory model that needs the exact order in which columns are touched. A start strobe loads a start column, a burst length code and an order select. The block then steps through the beats and flags the final one.

The block has two wrap orders. In sequential order the low address bits count up and wrap inside an aligned block of the burst length. In interleaved order the low bits are the start column's low bits XORed with the beat index. A full-page sequential mode walks every column, wrapping modulo the page size, and stops only on a stop strobe or a new start. A stop strobe ends the running burst. A new start, which may come on any clock, cuts the running burst short and begins the new one.

Top module: `bcol_seq`

## Requirements
- R1: While and after reset, with no start yet seen, `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: A clock edge with `start_i` high makes the next cycle show beat 0: `valid_o` = 1 and `col_o` equal to the sampled `start_col_i`.
- R3: Length code `len_i` 0, 1, 2, 3 gives bursts of 1, 2, 4, 8 beats. `valid_o` stays high for exactly that many cycles with one beat per cycle, `last_o` is high only on the final beat, and `valid_o` falls the cycle after unless a new start arrives.
- R4: In sequential order (`ilv_i` = 0), beat n has `col_o` bits above log2(L) equal to the start column's, and low log2(L) bits equal to (start low bits + n) mod L.
- R5: In interleaved order (`ilv_i` = 1), beat n has the upper bits of the start column and low log2(L) bits equal to the start column's low bits XOR n.
- R6: Length code 7 with sequential order is a full page: beat n is (start + n) mod 512. `last_o` never rises, and the burst runs until a stop or a new start.
- R7: Length codes 4, 5 and 6, and code 7 with interleaved order, give a single-beat burst.
- R8: `stop_i` high at an edge without `start_i` makes `valid_o` and `last_o` 0 from the next cycle on.
- R9: `start_i` during a running burst cuts it off. The next cycle shows beat 0 of the new burst, and `start_i` wins over `stop_i` when both are high.
- R10: Starts on consecutive clocks are all accepted, each showing its own beat 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new burst this edge |
| start_col_i | input | 9 | Start column of the new burst |
| len_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_i | input | 1 | End the running burst |
| col_o | output | 9 | Column of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final beat |

## Verification
The hardest state to reach is a full-page burst that wraps past column 511 and keeps running. The stimulus has to hold off stops and new starts for hundreds of cycles, so a directed case starts a full page near the top of the page and lets it run 600 beats. The other hard cases are same-edge stop and start, and starts on every clock. Directed sequences cover these, and seeded random traffic mixes all length codes, both orders and random truncation.

// File: rtl/bcol_pkg.sv
package bcol_pkg;
  localparam int unsigned COL_W = 9;
  localparam int unsigned LEN_W = 3;

  localparam logic [LEN_W-1:0] LC_1    = 3'd0;
  localparam logic [LEN_W-1:0] LC_2    = 3'd1;
  localparam logic [LEN_W-1:0] LC_4    = 3'd2;
  localparam logic [LEN_W-1:0] LC_8    = 3'd3;
  localparam logic [LEN_W-1:0] LC_PAGE = 3'd7;

  typedef struct packed {
    logic [COL_W-1:0] mask;  // low bits that move within the burst
    logic             full;  // full-page run
  } burst_cfg_t;
endpackage

// File: rtl/bcol_len_dec.sv
module bcol_len_dec
  import bcol_pkg::*;
#(
  parameter int unsigned CW = COL_W
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             ilv_i,
  output logic [CW-1:0]    mask_o,
  output logic             full_o
);
  localparam logic [CW-1:0] M1 = CW'(0);
  localparam logic [CW-1:0] M2 = CW'(1);
  localparam logic [CW-1:0] M4 = CW'(3);
  localparam logic [CW-1:0] M8 = CW'(7);

  always_comb begin
    mask_o = M1;
    full_o = 1'b0;
    unique case (len_i)
      LC_1:    mask_o = M1;
      LC_2:    mask_o = M2;
      LC_4:    mask_o = M4;
      LC_8:    mask_o = M8;
      LC_PAGE: begin
        // full page exists only for sequential order
        if (!ilv_i) begin
          mask_o = '1;
          full_o = 1'b1;
        end
      end
      default: mask_o = M1;
    endcase
  end
endmodule

// File: rtl/bcol_addr_map.sv
module bcol_addr_map #(
  parameter int unsigned CW = 9
) (
  input  logic [CW-1:0] base_i,
  input  logic [CW-1:0] beat_i,
  input  logic [CW-1:0] mask_i,
  input  logic          ilv_i,
  output logic [CW-1:0] col_o
);
  logic [CW-1:0] seq_lo;
  logic [CW-1:0] ilv_lo;

  assign seq_lo = base_i + beat_i;
  assign ilv_lo = base_i ^ beat_i;
  assign col_o  = (base_i & ~mask_i) | ((ilv_i ? ilv_lo : seq_lo) & mask_i);
endmodule

// File: rtl/bcol_seq.sv
module bcol_seq
  import bcol_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  burst_cfg_t       dec_cfg;
  burst_cfg_t       cfg_q;
  logic             act_q;
  logic             ilv_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic             at_end;

  bcol_len_dec #(.CW(COL_W)) u_dec (
    .len_i  (len_i),
    .ilv_i  (ilv_i),
    .mask_o (dec_cfg.mask),
    .full_o (dec_cfg.full)
  );

  bcol_addr_map #(.CW(COL_W)) u_map (
    .base_i (base_q),
    .beat_i (beat_q),
    .mask_i (cfg_q.mask),
    .ilv_i  (ilv_q),
    .col_o  (col_o)
  );

  assign at_end  = !cfg_q.full && (beat_q == cfg_q.mask);
  assign valid_o = act_q;
  assign last_o  = act_q && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      ilv_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      cfg_q  <= '0;
    end else if (start_i) begin
      // new column command truncates whatever runs
      act_q  <= 1'b1;
      ilv_q  <= ilv_i;
      base_q <= start_col_i;
      beat_q <= '0;
      cfg_q  <= dec_cfg;
    end else if (stop_i) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      if (at_end) act_q <= 1'b0;
      else        beat_q <= beat_q + ONE;
    end
  end

  a_r2_beat0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  a_r3_end_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);

  a_r8_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (!valid_o && !last_o));

  a_r6_page_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cfg_q.full && !start_i && !stop_i) |=> (valid_o && !last_o));

  a_r4_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !start_i && !stop_i)
      |=> (((col_o ^ $past(col_o)) & ~cfg_q.mask) == '0));

  a_r3_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
endmodule

// File: tb/tb_bcol_seq.sv
module tb_bcol_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] len_i = '0;
  logic       ilv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o;
  logic       last_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model
  bit    m_act = 0;
  int    m_start = 0;
  int    m_n = 0;
  int    m_len = 1;  // 0 = full page
  bit    m_ilv = 0;
  string cur_tag = "R3";

  always #5 clk_i = ~clk_i;

  bcol_seq dut (.*);

  function automatic int beats_of(input int code, input bit ilv);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return ilv ? 1 : 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int st, input int n, input int len, input bit ilv);
    int lo, hi;
    if (len == 0) return (st + n) % 512;
    hi = st - (st % len);
    lo = ilv ? ((st % len) ^ n) : ((st % len + n) % len);
    return hi + lo;
  endfunction

  task automatic do_check();
    bit    ev, el;
    int    ec;
    string tg;
    ev = m_act;
    el = m_act && m_len != 0 && m_n == m_len - 1;
    ec = m_act ? exp_col(m_start, m_n, m_len, m_ilv) : int'(col_o);
    tg = (m_act && m_n == 0) ? "R2" : cur_tag;
    n_run++;
    if (valid_o !== ev || last_o !== el || int'(col_o) != ec) begin
      n_fail++;
      $display("FAIL %s: col/valid/last got %0h/%0b/%0b exp %0h/%0b/%0b",
               tg, col_o, valid_o, last_o, ec, ev, el);
    end
  endtask

  task automatic step(input bit s, input int col, input int code, input bit ilv,
                      input bit stp, input string tag);
    @(negedge clk_i);
    do_check();
    start_i = s; start_col_i = 9'(col); len_i = 3'(code); ilv_i = ilv; stop_i = stp;
    @(posedge clk_i);
    if (s) begin
      m_act = 1; m_start = col; m_n = 0; m_len = beats_of(code, ilv); m_ilv = ilv;
      cur_tag = tag;
    end else if (stp) begin
      m_act = 0;
    end else if (m_act) begin
      if (m_len != 0 && m_n == m_len - 1) m_act = 0;
      else m_n++;
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, cur_tag);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    #23;
    // R1 reset state
    n_run++;
    if (valid_o !== 0 || last_o !== 0 || col_o !== 0) begin
      n_fail++;
      $display("FAIL R1: col/valid/last got %0h/%0b/%0b exp 0/0/0", col_o, valid_o, last_o);
    end
    rst_ni = 1'b1;
    idle(2);
    // R4 sequential wrap in aligned block of 8
    step(1, 'h1FD, 3, 0, 0, "R4"); idle(9);
    step(1, 'h0A6, 2, 0, 0, "R4"); idle(5);
    step(1, 'h011, 1, 0, 0, "R3"); idle(3);
    step(1, 'h123, 0, 0, 0, "R3"); idle(2);
    // R5 interleave
    step(1, 'h0A6, 2, 1, 0, "R5"); idle(5);
    step(1, 'h15D, 3, 1, 0, "R5"); idle(9);
    // R6 full page wraps past 511
    step(1, 'h1FE, 7, 0, 0, "R6"); idle(600);
    step(0, 0, 0, 0, 1, "R8"); idle(3);
    // R7 reserved codes and interleaved full page
    step(1, 'h0F3, 5, 0, 0, "R7"); idle(2);
    step(1, 'h0F3, 4, 1, 0, "R7"); idle(2);
    step(1, 'h0F3, 6, 0, 0, "R7"); idle(2);
    step(1, 'h0F3, 7, 1, 0, "R7"); idle(3);
    // R8 stop mid burst
    step(1, 'h040, 3, 0, 0, "R8"); idle(2);
    step(0, 0, 0, 0, 1, "R8"); idle(3);
    // R9 truncation, start wins over stop
    step(1, 'h080, 3, 0, 0, "R9"); idle(2);
    step(1, 'h105, 2, 1, 1, "R9"); idle(6);
    // R10 back-to-back starts
    for (int i = 0; i < 6; i++) step(1, 37 * i + 3, i % 4, i[0], 0, "R10");
    idle(10);
    // seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 100);
      if ((!m_act && r < 30) || (m_act && r < 5))
        step(1, int'($urandom % 512), int'($urandom % 8), 1'($urandom % 2), 1'($urandom % 2), "R3");
      else if (m_act && r < 10)
        step(0, 0, 0, 0, 1, "R8");
      else
        step(0, 0, 0, 0, 0, cur_tag);
    end
    @(negedge clk_i);
    do_check();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule